// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Rotator

This block rotates a two-dimensional vector through a given angle using only shifts, additions and a small table of arctangent constants. It applies one micro-rotation per clock. After a fixed count of steps the residual angle has been driven close to zero, and the vector has turned through the requested angle. Each step also scales the vector by a known gain of about 1.6468.

To obtain cosine and sine, load x with the gain-compensation constant 19896 (about 0.607 in Q1.15) and y with 0. The results then land in x (cosine) and y (sine) as Q1.15 values. Any other start vector is rotated and scaled by the same gain.

The angle is accepted in one of two fixed-point formats, selected per operation by a mode bit. The first is radians with one integer bit and fifteen fraction bits, where 90 degrees is 51471. The second is degrees with eight integer bits and eight fraction bits, where 90 degrees is 23040. Each format has its own arctangent table. The residual angle is brought out next to x and y. The valid angle range is 0 to 90 degrees.

Operands arrive on a valid/ready input. `in_ready` is high exactly when the engine is idle, and an operand is taken on a clock edge where `in_valid` and `in_ready` are both high. The output side has no back-pressure: `out_valid` is a one-cycle pulse, and the result registers then hold their values until the next operand is accepted. A consumer that cannot take the result in the pulse cycle must hold off the next operand.

Top module: `cordic_rot`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `out_valid` are low, `in_ready` is high, and `out_x`, `out_y` and `out_z` are 0.
- R2: An operand is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` equals the inverse of `busy`, and `busy` is high from the edge after acceptance.
- R3: Exactly 16 clock edges after the accepting edge, `busy` falls and `out_valid` is high for exactly one cycle.
- R4: While `busy` is high, `in_valid` is ignored: the operands presented then do not change the result of the operation in progress.
- R5: With `in_mode` = 0, the angle is radians in Q1.15 (bit 16 sign, bit 15 integer, bits 14:0 fraction). With x = 19896 and y = 0, `out_x` and `out_y` match cos and sin of the angle within ±12 LSB for angles from 0 to 90 degrees.
- R6: With `in_mode` = 1, the angle is degrees in 8.8 form (bit 16 sign, bits 15:8 integer degrees, bits 7:0 fraction). With x = 19896 and y = 0, `out_x` and `out_y` match cos and sin within ±48 LSB for angles from 0 to 90 degrees.
- R7: A general start vector (x, y) ends as G·(x·cosθ − y·sinθ, x·sinθ + y·cosθ), where G is the product of sqrt(1 + 2^(−2i)) for i = 0..15. The tolerance is that of the selected mode.
- R8: At completion, the residual angle `out_z` is within ±4 LSB in radian mode and within ±8 LSB in degree mode.
- R9: The mode bit is sampled only when an operand is accepted. Changing `in_mode` while `busy` is high has no effect on the running operation.
- R10: Once `out_valid` has pulsed, `out_x`, `out_y` and `out_z` hold their values until the next operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Engine idle, operand will be taken |
| in_mode | input | 1 | Angle format: 0 radian Q1.15, 1 degree 8.8 |
| in_x | input | 17 | Start x, signed Q1.15 |
| in_y | input | 17 | Start y, signed Q1.15 |
| in_ang | input | 17 | Rotation angle, signed, format per `in_mode` |
| busy | output | 1 | Micro-rotations in progress |
| out_valid | output | 1 | One-cycle pulse: result ready |
| out_x | output | 17 | Rotated x (cosine for the unit start vector) |
| out_y | output | 17 | Rotated y (sine for the unit start vector) |
| out_z | output | 17 | Residual angle, format of the captured mode |

## Verification
A wrong step counter shows at the ports as an `out_valid` pulse that comes too early or too late. The per-clock handshake model catches this within the first operation. A wrong table entry, a wrong table selection or a wrong rotation direction leaves a large residual angle and sine/cosine errors far outside tolerance, which are seen at the first completion. Operands or a mode that leak in while busy show up as a result that belongs to the wrong angle. Result registers that are disturbed after completion are seen within a few idle cycles, while the outputs should be holding.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Maximum micro-rotation count covered by the constant tables
  localparam int MAX_ITER = 16;

  // atan(2^-i) scaled by 2^15 (radians, one integer bit)
  localparam int unsigned ATAN_RAD [0:MAX_ITER-1] = '{
    25736, 15193, 8027, 4075, 2045, 1024, 512, 256,
    128, 64, 32, 16, 8, 4, 2, 1
  };

  // atan(2^-i) in degrees scaled by 2^8
  localparam int unsigned ATAN_DEG [0:MAX_ITER-1] = '{
    11520, 6801, 3593, 1824, 916, 458, 229, 115,
    57, 29, 14, 7, 4, 2, 1, 0
  };

  typedef enum logic {
    ANG_RAD = 1'b0,
    ANG_DEG = 1'b1
  } ang_mode_e;

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
  import cordic_pkg::*;
#(
  parameter int W     = 17,
  parameter int ITER  = 16,
  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic [IDX_W-1:0]    idx,
  input  ang_mode_e           mode,
  output logic signed [W-1:0] atan_val
);

  logic signed [W-1:0] rad_tab [ITER];
  logic signed [W-1:0] deg_tab [ITER];

  generate
    for (genvar i = 0; i < ITER; i++) begin : g_tab
      assign rad_tab[i] = W'(ATAN_RAD[i]);
      assign deg_tab[i] = W'(ATAN_DEG[i]);
    end
  endgenerate

  always_comb begin
    if (mode == ANG_DEG) atan_val = deg_tab[idx];
    else                 atan_val = rad_tab[idx];
  end

endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
  parameter int W     = 17,
  parameter int IDX_W = 4
) (
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  input  logic [IDX_W-1:0]    shamt,
  input  logic signed [W-1:0] atan_val,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out
);

  logic signed [W-1:0] x_sh;
  logic signed [W-1:0] y_sh;
  logic                turn_neg;

  assign x_sh     = x_in >>> shamt;
  assign y_sh     = y_in >>> shamt;
  assign turn_neg = z_in[W-1];

  // Rotate toward the sign of the residual angle
  always_comb begin
    if (turn_neg) begin
      x_out = x_in + y_sh;
      y_out = y_in - x_sh;
      z_out = z_in + atan_val;
    end else begin
      x_out = x_in - y_sh;
      y_out = y_in + x_sh;
      z_out = z_in - atan_val;
    end
  end

endmodule

// File: rtl/cordic_seq.sv
module cordic_seq #(
  parameter int ITER  = 16,
  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] step,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(ITER - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (step == LAST_STEP) begin
          busy <= 1'b0;
          done <= 1'b1;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cordic_rot.sv
module cordic_rot
  import cordic_pkg::*;
#(
  parameter int W    = 17,
  parameter int ITER = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_mode,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic signed [W-1:0] in_ang,
  output logic                busy,
  output logic                out_valid,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y,
  output logic signed [W-1:0] out_z
);

  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1;

  logic                accept;
  logic [IDX_W-1:0]    step;
  ang_mode_e           mode_q;
  logic signed [W-1:0] x_q, y_q, z_q;
  logic signed [W-1:0] x_nx, y_nx, z_nx;
  logic signed [W-1:0] atan_val;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  cordic_seq #(.ITER(ITER)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .step  (step),
    .done  (out_valid)
  );

  cordic_atan_rom #(.W(W), .ITER(ITER)) u_rom (
    .idx      (step),
    .mode     (mode_q),
    .atan_val (atan_val)
  );

  cordic_microrot #(.W(W), .IDX_W(IDX_W)) u_rot (
    .x_in     (x_q),
    .y_in     (y_q),
    .z_in     (z_q),
    .shamt    (step),
    .atan_val (atan_val),
    .x_out    (x_nx),
    .y_out    (y_nx),
    .z_out    (z_nx)
  );

  // Working registers double as result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      mode_q <= ANG_RAD;
    end else if (accept) begin
      x_q    <= in_x;
      y_q    <= in_y;
      z_q    <= in_ang;
      mode_q <= ang_mode_e'(in_mode);
    end else if (busy) begin
      x_q <= x_nx;
      y_q <= y_nx;
      z_q <= z_nx;
    end
  end

  assign out_x = x_q;
  assign out_y = y_q;
  assign out_z = z_q;

endmodule

// File: rtl/cordic_rot_chk.sv
module cordic_rot_chk #(
  parameter int W    = 17,
  parameter int ITER = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                busy,
  input logic                out_valid,
  input logic signed [W-1:0] out_x,
  input logic signed [W-1:0] out_y,
  input logic signed [W-1:0] out_z
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= 0;
    else if (busy)  run_len <= run_len + 1;
    else            run_len <= 0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !out_valid));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!busy && $past(busy)));

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_len == ITER));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> ($stable(out_x) && $stable(out_y) && $stable(out_z)));

endmodule

bind cordic_rot cordic_rot_chk #(.W(W), .ITER(ITER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .out_valid (out_valid),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_z     (out_z)
);

// File: tb/tb_cordic_rot.sv
module tb_cordic_rot;

  localparam int CLK_P = 10;
  localparam int W     = 17;
  localparam int ITER  = 16;
  localparam real PI   = 3.14159265358979;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_mode = 1'b0;
  logic signed [W-1:0] in_x = '0;
  logic signed [W-1:0] in_y = '0;
  logic signed [W-1:0] in_ang = '0;
  logic                in_ready, busy, out_valid;
  logic signed [W-1:0] out_x, out_y, out_z;

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cordic_rot #(.W(W), .ITER(ITER)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_x(in_x), .in_y(in_y), .in_ang(in_ang),
    .busy(busy), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural handshake model, advanced on every rising edge
  bit m_busy = 0;
  bit m_ov   = 0;
  int m_cnt  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ov = 0; m_cnt = 0;
    end else begin
      m_ov = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == ITER) begin
          m_busy = 0;
          m_ov   = 1;
        end
      end else if (in_valid) begin
        m_busy = 1;
        m_cnt  = 0;
      end
    end
  end

  // Per-clock comparison against the model (R2, R3)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R2", "busy vs model", int'(busy), int'(m_busy));
      check(in_ready == !m_busy, "R2", "in_ready vs model", int'(in_ready), int'(!m_busy));
      check(out_valid == m_ov, "R3", "out_valid vs model", int'(out_valid), int'(m_ov));
    end
  end

  function automatic real gain();
    real g = 1.0;
    for (int i = 0; i < ITER; i++) g = g * $sqrt(1.0 + 1.0 / (4.0 ** i));
    return g;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // One operation; disturb drives junk operands and flips the mode while busy
  task automatic run_op(bit mode, int x, int y, int ang, bit disturb, string req);
    real th, ex, ey;
    int  tol, ztol, waited, hx, hy, hz;
    th   = mode ? (real'(ang) / 256.0) * PI / 180.0 : real'(ang) / 32768.0;
    ex   = gain() * (real'(x) * $cos(th) - real'(y) * $sin(th));
    ey   = gain() * (real'(x) * $sin(th) + real'(y) * $cos(th));
    tol  = mode ? 48 : 12;
    ztol = mode ? 8 : 4;
    @(negedge clk);
    in_valid = 1; in_mode = mode;
    in_x = W'(x); in_y = W'(y); in_ang = W'(ang);
    @(negedge clk);
    in_valid = 0;
    waited = 0;
    while (!out_valid && waited < 40) begin
      if (disturb && waited < 10) begin
        in_valid = 1; in_mode = ~mode;
        in_x = W'(-5000); in_y = W'(7000); in_ang = W'(3000);
      end else begin
        in_valid = 0;
      end
      @(negedge clk);
      waited++;
    end
    in_valid = 0;
    check(waited == ITER, "R3", "latency in clocks", waited, ITER);
    check(iabs(int'(out_x) - $rtoi(ex)) <= tol, req, "out_x", int'(out_x), $rtoi(ex));
    check(iabs(int'(out_y) - $rtoi(ey)) <= tol, req, "out_y", int'(out_y), $rtoi(ey));
    check(iabs(int'(out_z)) <= ztol, "R8", "residual out_z", int'(out_z), 0);
    hx = int'(out_x); hy = int'(out_y); hz = int'(out_z);
    repeat (3) @(negedge clk);
    check(int'(out_x) == hx && int'(out_y) == hy && int'(out_z) == hz,
          "R10", "result hold out_x", int'(out_x), hx);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 while reset is held
    check(busy == 0 && out_valid == 0, "R1", "busy/out_valid in reset", int'(busy), 0);
    check(in_ready == 1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check(out_x == 0 && out_y == 0 && out_z == 0, "R1", "outputs after reset", int'(out_x), 0);
    check(in_ready == 1 && busy == 0, "R1", "idle after reset", int'(busy), 0);

    // R5 radian mode, unit start vector
    run_op(1'b0, 19896, 0, 0,     1'b0, "R5");
    run_op(1'b0, 19896, 0, 571,   1'b0, "R5");
    run_op(1'b0, 19896, 0, 17157, 1'b0, "R5");
    run_op(1'b0, 19896, 0, 25735, 1'b0, "R5");
    run_op(1'b0, 19896, 0, 34314, 1'b0, "R5");
    run_op(1'b0, 19896, 0, 51471, 1'b0, "R5");

    // R6 degree mode, unit start vector
    run_op(1'b1, 19896, 0, 0,     1'b0, "R6");
    run_op(1'b1, 19896, 0, 7680,  1'b0, "R6");
    run_op(1'b1, 19896, 0, 11520, 1'b0, "R6");
    run_op(1'b1, 19896, 0, 15488, 1'b0, "R6");
    run_op(1'b1, 19896, 0, 23040, 1'b0, "R6");

    // R7 general start vectors in both modes
    run_op(1'b0, 10000, 5000,  17157, 1'b0, "R7");
    run_op(1'b1, 12000, -4000, 5120,  1'b0, "R7");

    // R4 and R9: junk operands and a flipped mode while busy
    run_op(1'b0, 19896, 0, 25735, 1'b1, "R4");
    run_op(1'b1, 19896, 0, 15360, 1'b1, "R9");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule